// File: doc/BRIEF.md
# GPIO Controller with Both-Edge Change Interrupts

This block is a general-purpose I/O controller for a parameterised number of lines (up to 32). Software reaches it through a plain word-wide register port: a write strobe with address and data, and a combinational read data bus that follows the address. Each line can be an input or an output. The block has one data register. Writes to it set the output levels. Reads from it return the driven value for output lines and the synchronised pin level for input lines. A separate mask register chooses which data bits a write may change.

Every input line passes through a multi-flop synchroniser. Any rise or fall seen after the synchroniser sets a sticky per-line change flag. Software clears a flag by writing a one to it. A single interrupt output is high while any flagged line also has its enable bit set. Only both-edge detection exists, and a read-only type register reports this by returning all ones.

Top module: `gpio_edge_top`

## Requirements
- R1: After reset the direction, data, enable and change registers read zero, the mask register reads ones on every implemented line, pinOe is all zero and irq is low.
- R2: A 1 in the direction register (offset 0x00) makes that line an output: its pinOe bit is high and pinOut carries the data register bit. A 0 makes it an input.
- R3: A read of the data register (offset 0x04) returns the stored value on output lines and the synchronised pin level on input lines. A pin change shows in the read value after the second rising clock edge, and not after the first.
- R4: A write to the data register changes only those bits whose bit in the mask register (offset 0x10) is 1. The other bits keep their value.
- R5: A rising or falling transition on an input line sets that line's bit in the change register (offset 0x0C) at the third rising edge after the pin change, and the bit then stays set. A transition on an output line sets no change bit.
- R6: Writing 1 to a change bit clears it. Writing 0 leaves it as it was.
- R7: If a new edge on a line reaches the change register in the same cycle as a write-one clear of that bit, the bit stays set.
- R8: irq is high exactly while some line has both its change bit and its enable bit (offset 0x08) set. It follows a register update in the same cycle, with no added latency.
- R9: The type register (offset 0x14) always reads 0xFFFFFFFF, and writes to it have no effect.
- R10: Registers are decoded at word-aligned byte offsets 0x00 to 0x14. Reads at any other address return zero, and writes there have no effect.
- R11: Bits at or above the line count read as zero in every register except the type register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register at addr (combinational) |
| pinIn | input | LINES | Pin levels from the pads (asynchronous) |
| pinOut | output | LINES | Output levels driven to the pads |
| pinOe | output | LINES | Per-line output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A change flag that is wrongly set or wrongly lost shows up on irq as soon as that line is enabled, and in the change register read in the same cycle. The edge timing is fixed, so the bench samples exactly one cycle before and at the expected edge. A synchroniser that is one stage too short or too long therefore fails at once. A wrong direction or mask bit shows on pinOe or pinOut right after the write that should have left it alone. An ack that wins over a new edge shows as a cleared flag on the next read.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int REG_W = 32;

  // word index of each register (byte offset / 4)
  localparam int IDX_DIR  = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_EN   = 2;
  localparam int IDX_CHG  = 3;
  localparam int IDX_MASK = 4;
  localparam int IDX_TYPE = 5;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_DATA = 3'd1,
    SEL_EN   = 3'd2,
    SEL_CHG  = 3'd3,
    SEL_MASK = 3'd4,
    SEL_TYPE = 3'd5,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic dirWr;
    logic dataWr;
    logic enWr;
    logic chgAck;
    logic maskWr;
  } regStrobe_t;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  dirVec,
  input  logic [LINES-1:0]  dataRd,
  input  logic [LINES-1:0]  enVec,
  input  logic [LINES-1:0]  chgVec,
  input  logic [LINES-1:0]  maskVec,
  output regStrobe_t        strb,
  output logic [REG_W-1:0]  rdData
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  regSel_e          regSel;
  logic [LINES-1:0] lineVal;

  assign wordIdx = addr[ADDR_W-1:2];

  always_comb begin
    regSel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if      (wordIdx == IDX_W'(IDX_DIR))  regSel = SEL_DIR;
      else if (wordIdx == IDX_W'(IDX_DATA)) regSel = SEL_DATA;
      else if (wordIdx == IDX_W'(IDX_EN))   regSel = SEL_EN;
      else if (wordIdx == IDX_W'(IDX_CHG))  regSel = SEL_CHG;
      else if (wordIdx == IDX_W'(IDX_MASK)) regSel = SEL_MASK;
      else if (wordIdx == IDX_W'(IDX_TYPE)) regSel = SEL_TYPE;
    end
  end

  always_comb begin
    strb        = '0;
    strb.dirWr  = wrEn && (regSel == SEL_DIR);
    strb.dataWr = wrEn && (regSel == SEL_DATA);
    strb.enWr   = wrEn && (regSel == SEL_EN);
    strb.chgAck = wrEn && (regSel == SEL_CHG);
    strb.maskWr = wrEn && (regSel == SEL_MASK);
  end

  always_comb begin
    case (regSel)
      SEL_DIR:  lineVal = dirVec;
      SEL_DATA: lineVal = dataRd;
      SEL_EN:   lineVal = enVec;
      SEL_CHG:  lineVal = chgVec;
      SEL_MASK: lineVal = maskVec;
      default:  lineVal = '0;
    endcase
    rdData = '0;
    if (regSel == SEL_TYPE) rdData = '1;
    else                    rdData[LINES-1:0] = lineVal;
  end

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [LINES-1:0] wrBits,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic [LINES-1:0] dirVec,
  output logic [LINES-1:0] dataRd,
  output logic [LINES-1:0] enVec,
  output logic [LINES-1:0] chgVec,
  output logic [LINES-1:0] maskVec,
  output logic             irq
);

  logic [LINES-1:0] dirQ, dataQ, enQ, chgQ, maskQ, prevQ;
  logic [LINES-1:0] pinSync, edgeVec, ackVec;

  gpio_edge_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  // both-edge detect, input lines only
  assign edgeVec = (pinSync ^ prevQ) & ~dirQ;
  assign ackVec  = strb.chgAck ? wrBits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      dataQ <= '0;
      enQ   <= '0;
      chgQ  <= '0;
      maskQ <= '1;
      prevQ <= '0;
    end else begin
      prevQ <= pinSync;
      if (strb.dirWr)  dirQ  <= wrBits;
      if (strb.enWr)   enQ   <= wrBits;
      if (strb.maskWr) maskQ <= wrBits;
      if (strb.dataWr) dataQ <= (dataQ & ~maskQ) | (wrBits & maskQ);
      // a fresh edge outranks a clear in the same cycle
      chgQ <= (chgQ & ~ackVec) | edgeVec;
    end
  end

  assign pinOut  = dataQ;
  assign pinOe   = dirQ;
  assign dirVec  = dirQ;
  assign enVec   = enQ;
  assign chgVec  = chgQ;
  assign maskVec = maskQ;
  assign dataRd  = (dirQ & dataQ) | (~dirQ & pinSync);
  assign irq     = |(chgQ & enQ);

endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
  import gpio_edge_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic              irq
);

  regStrobe_t       strb;
  logic [LINES-1:0] dirVec, dataRd, enVec, chgVec, maskVec;

  gpio_edge_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .dirVec  (dirVec),
    .dataRd  (dataRd),
    .enVec   (enVec),
    .chgVec  (chgVec),
    .maskVec (maskVec),
    .strb    (strb),
    .rdData  (rdData)
  );

  gpio_edge_dp #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBits  (wrData[LINES-1:0]),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .dirVec  (dirVec),
    .dataRd  (dataRd),
    .enVec   (enVec),
    .chgVec  (chgVec),
    .maskVec (maskVec),
    .irq     (irq)
  );

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_edge_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic [LINES-1:0]  pinOut,
  input logic              irq,
  input regStrobe_t        strb,
  input logic [LINES-1:0]  dirVec,
  input logic [LINES-1:0]  chgVec,
  input logic [LINES-1:0]  maskVec
);

  // R4: a data write with an all-zero mask leaves the pins alone
  p_masked_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && maskVec == '0) |=> $stable(pinOut));

  // R5: no change bit appears on a line that was an output
  p_out_no_change_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((chgVec & ~$past(chgVec) & $past(dirVec)) == '0));

  // R6: a change bit not hit by a write-one clear stays set
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(chgVec) &
                ~($past(strb.chgAck) ? $past(wrData[LINES-1:0]) : '0))
               & ~chgVec) == '0));

  // R8: clearing every enable drops the interrupt on the next cycle
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enWr && wrData[LINES-1:0] == '0) |=> !irq);

  // R9: the type register always reads all ones
  p_type_ones_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(IDX_TYPE * 4)) |-> (rdData == 32'hFFFF_FFFF));

endmodule

bind gpio_edge_top gpio_edge_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .pinOut  (pinOut),
  .irq     (irq),
  .strb    (strb),
  .dirVec  (dirVec),
  .chgVec  (chgVec),
  .maskVec (maskVec)
);

// File: tb/test_gpio_edge_top.sv
`timescale 1ns/1ps
module test_gpio_edge_top;

  localparam int LINES  = 8;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_DIR = 5'h00, A_DATA = 5'h04, A_EN = 5'h08,
                         A_CHG = 5'h0C, A_MASK = 5'h10, A_TYPE = 5'h14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [LINES-1:0]  pinIn = '0;
  logic [LINES-1:0]  pinOut, pinOe;
  logic              irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_edge_top #(.LINES(LINES), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_gpio_edge_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    readReg(A_DIR, v);  check("R1 dir", v, 0);
    readReg(A_DATA, v); check("R1 data", v, 0);
    readReg(A_EN, v);   check("R1 en", v, 0);
    readReg(A_CHG, v);  check("R1 chg", v, 0);
    readReg(A_MASK, v); check("R1 R11 mask", v, 32'h0000_00FF);
    readReg(A_TYPE, v); check("R9 type", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 pinOe", {24'd0, pinOe}, 0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    writeReg(A_DIR, 32'h0F);
    writeReg(A_DATA, 32'hA5);
    check("R2 pinOe", {24'd0, pinOe}, 32'h0F);
    check("R2 pinOut", {24'd0, pinOut}, 32'hA5);
    pinIn = 8'hFF;
    waitClk(1);
    readReg(A_DATA, v); check("R3 one edge", v, 32'h05);
    waitClk(1);
    readReg(A_DATA, v); check("R3 two edges", v, 32'hF5);
    waitClk(2);
    readReg(A_CHG, v);  check("R5 output lines", v, 32'hF0);
    writeReg(A_CHG, 32'hFF);
    readReg(A_CHG, v);  check("R6 clear all", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    writeReg(A_MASK, 32'h0F);
    writeReg(A_DATA, 32'hFF);
    check("R4 masked write", {24'd0, pinOut}, 32'hAF);
    writeReg(A_MASK, 32'hFF);
    writeReg(A_DATA, 32'h00);
    check("R4 full mask", {24'd0, pinOut}, 32'h00);
    writeReg(A_DIR, 32'hFFFF_FFFF);
    readReg(A_DIR, v); check("R11 upper bits", v, 32'hFF);
    writeReg(A_DIR, 32'h0);
    pinIn = 8'h00;
    waitClk(4);
    writeReg(A_CHG, 32'hFF);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    pinIn = 8'h04;
    waitClk(2);
    readReg(A_CHG, v); check("R5 rise not yet", v, 0);
    waitClk(1);
    readReg(A_CHG, v); check("R5 rise", v, 32'h04);
    writeReg(A_CHG, 32'h04);
    pinIn = 8'h00;
    waitClk(3);
    readReg(A_CHG, v); check("R5 fall", v, 32'h04);
    pinIn = 8'h01;
    waitClk(3);
    readReg(A_CHG, v); check("R5 sticky", v, 32'h05);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    writeReg(A_CHG, 32'h00);
    readReg(A_CHG, v); check("R6 write zero", v, 32'h05);
    writeReg(A_CHG, 32'h01);
    readReg(A_CHG, v); check("R6 write one", v, 32'h04);
  endtask

  task automatic t_irq();
    writeReg(A_EN, 32'h02);
    check("R8 disabled", {31'd0, irq}, 0);
    writeReg(A_EN, 32'h04);
    check("R8 enabled", {31'd0, irq}, 1);
    writeReg(A_CHG, 32'h04);
    check("R8 acked", {31'd0, irq}, 0);
    writeReg(A_EN, 32'h00);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pinIn = 8'h09;
    waitClk(3);
    readReg(A_CHG, v); check("R7 setup", v, 32'h08);
    pinIn = 8'h01;
    waitClk(2);
    wrEn = 1'b1; addr = A_CHG; wrData = 32'h08;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    readReg(A_CHG, v); check("R7 edge wins", v, 32'h08);
    writeReg(A_CHG, 32'h08);
    readReg(A_CHG, v); check("R7 later clear", v, 0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    writeReg(A_TYPE, 32'h0);
    readReg(A_TYPE, v); check("R9 write ignored", v, 32'hFFFF_FFFF);
    writeReg(5'h18, 32'hFF);
    readReg(5'h18, v); check("R10 unmapped read", v, 0);
    readReg(A_DIR, v); check("R10 unmapped write dir", v, 0);
    readReg(A_EN, v);  check("R10 unmapped write en", v, 0);
    readReg(5'h05, v); check("R10 unaligned", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_mask();
    t_edges();
    t_ack();
    t_irq();
    t_collide();
    t_decode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule